// File: doc/BRIEF.md
# DMA Request Burst Pacer

This block paces the request line of a device-side DMA port. Software programs a burst length, a bus width (16 or 32 bits) and a transfer length in bytes, then pulses `start`. The pacer raises `dreq` while bytes are still owed. Each read or write strobe from the external DMA master is counted as one bus word. When a burst has been fully moved, `dreq` falls for one clock and then rises again for the next burst. After the final strobe of the transfer it falls for good and a one-cycle `done` pulse is given.

The configuration is checked when `start` is sampled. A zero burst, a burst that is not a whole number of bus words, or a transfer length that is not a whole number of bursts raises `cfg_err`, and no request is made. There is no data path and no buffering. The only flow control is `dreq` itself: a strobe counts only while `dreq` is high, and the DMA master applies back-pressure by leaving `strobe` low.

Top module: `dma_burst_pacer`

## Requirements
- R1: After reset, `dreq`, `done` and `cfg_err` are all low.
- R2: A `start` sampled while idle, with a valid configuration and a nonzero `xfer_len`, raises `dreq` in the next cycle. Only bits 12:0 of `cfg_burst` form the burst length in bytes; bits 15:13 have no effect.
- R3: With `cfg_wide`=0 (16-bit) the burst must be a nonzero multiple of 2. With `cfg_wide`=1 (32-bit) it must be a nonzero multiple of 4. A `start` with any other burst raises `cfg_err` in the next cycle and `dreq` stays low.
- R4: A `start` with an `xfer_len` that is not an exact multiple of the burst length raises `cfg_err` in the next cycle and `dreq` stays low.
- R5: A strobe sampled while `dreq` is high moves 2 bytes in 16-bit mode and 4 bytes in 32-bit mode. Strobes sampled while `dreq` is low are ignored. The bytes moved over a transfer equal `xfer_len`.
- R6: When a burst completes and bytes remain, `dreq` is low for exactly one cycle and then high again.
- R7: With the minimum burst (2 in 16-bit mode, 4 in 32-bit mode), `dreq` falls after every accepted strobe.
- R8: After the strobe that moves the last bytes, `done` is high for exactly one cycle and `dreq` is low. `dreq` stays low until the next valid `start`.
- R9: While a transfer is active, `start` and changes to `cfg_burst`, `cfg_wide` and `xfer_len` have no effect. The width and length are latched when the transfer starts.
- R10: `cfg_err` holds until the next idle `start`, and a valid start clears it. A valid start with `xfer_len`=0 gives a `done` pulse in the next cycle and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| cfg_burst | input | 16 | Burst length in bytes in bits 12:0; bits 15:13 ignored |
| cfg_wide | input | 1 | 1 = 32-bit bus (4 bytes per strobe), 0 = 16-bit bus (2 bytes per strobe) |
| xfer_len | input | 16 | Transfer length in bytes |
| strobe | input | 1 | Read/write strobe from the DMA master, one bus word |
| dreq | output | 1 | DMA request |
| done | output | 1 | One-cycle pulse when the transfer completes |
| cfg_err | output | 1 | Configuration rejected at the last start |

## Verification
A burst counter that drifts shows up as a `dreq` gap in the wrong cycle. A wrong remaining-byte count shows up as a `done` pulse that comes early or late. A per-cycle reference comparison catches either fault on the first clock where the ports differ, which is at most one burst after the fault. Totals of bytes moved, request drops and done pulses per transfer also catch a wrong step size or a missing final pulse, even when the timing looks plausible. Mid-transfer changes to the configuration and strobes during gaps are driven on purpose, so that wrongly latched or wrongly accepted inputs change the observed sequence.

// File: rtl/dma_pacer_pkg.sv
package dma_pacer_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_REQ  = 2'd1,
    PS_GAP  = 2'd2
  } pacer_state_e;

  localparam int unsigned STEP_NARROW = 2;
  localparam int unsigned STEP_WIDE   = 4;

  function automatic logic [2:0] bytes_per_strobe(input logic wide);
    return wide ? 3'(STEP_WIDE) : 3'(STEP_NARROW);
  endfunction
endpackage

// File: rtl/dma_pacer_cfg_check.sv
module dma_pacer_cfg_check #(
  parameter int CFG_W   = 16,
  parameter int BURST_W = 13,
  parameter int XLEN_W  = 16
) (
  input  logic [CFG_W-1:0]   cfg_burst,
  input  logic               cfg_wide,
  input  logic [XLEN_W-1:0]  xfer_len,
  output logic [BURST_W-1:0] burst_val,
  output logic               cfg_ok,
  output logic               xfer_zero
);
  localparam int DW = XLEN_W + BURST_W;

  logic [DW-1:0] num_w, den_w, rem_w;
  logic          gran_bad;

  assign burst_val = cfg_burst[BURST_W-1:0];
  assign gran_bad  = cfg_wide ? (|burst_val[1:0]) : burst_val[0];
  assign num_w     = DW'(xfer_len);
  assign den_w     = DW'(burst_val);

  always_comb begin
    if (den_w == '0) rem_w = '0;
    else             rem_w = num_w % den_w;
  end

  assign cfg_ok    = (burst_val != '0) && !gran_bad && (rem_w == '0);
  assign xfer_zero = (xfer_len == '0);
endmodule

// File: rtl/dma_pacer_counters.sv
module dma_pacer_counters
  import dma_pacer_pkg::*;
#(
  parameter int BURST_W = 13,
  parameter int XLEN_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               reload,
  input  logic               consume,
  input  logic               wide_in,
  input  logic [BURST_W-1:0] burst_in,
  input  logic [XLEN_W-1:0]  xfer_in,
  output logic               burst_end,
  output logic               xfer_last
);
  logic [BURST_W-1:0] burst_len_q, burst_cnt_q;
  logic [XLEN_W-1:0]  remain_q;
  logic [2:0]         step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_len_q <= '0;
      burst_cnt_q <= '0;
      remain_q    <= '0;
      step_q      <= 3'(STEP_NARROW);
    end else if (load) begin
      burst_len_q <= burst_in;
      burst_cnt_q <= burst_in;
      remain_q    <= xfer_in;
      step_q      <= bytes_per_strobe(wide_in);
    end else if (reload) begin
      burst_cnt_q <= burst_len_q;
    end else if (consume) begin
      burst_cnt_q <= burst_cnt_q - BURST_W'(step_q);
      remain_q    <= remain_q - XLEN_W'(step_q);
    end
  end

  assign burst_end = (burst_cnt_q == BURST_W'(step_q));
  assign xfer_last = (remain_q == XLEN_W'(step_q));

  // R5: a counted strobe never takes more bytes than remain
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> (remain_q >= XLEN_W'(step_q)) && (burst_cnt_q >= BURST_W'(step_q)));

  // R5: each counted strobe removes exactly one bus word
  p_step_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !load && !reload) |=> remain_q == $past(remain_q) - XLEN_W'($past(step_q)));
endmodule

// File: rtl/dma_pacer_seq.sv
module dma_pacer_seq
  import dma_pacer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_ok,
  input  logic xfer_zero,
  input  logic strobe,
  input  logic burst_end,
  input  logic xfer_last,
  output logic load,
  output logic reload,
  output logic consume,
  output logic dreq,
  output logic done,
  output logic cfg_err
);
  pacer_state_e state_q, state_d;
  logic         done_q, err_q;

  assign load    = (state_q == PS_IDLE) && start && cfg_ok && !xfer_zero;
  assign reload  = (state_q == PS_GAP);
  assign consume = (state_q == PS_REQ) && strobe;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: if (load) state_d = PS_REQ;
      PS_REQ: begin
        if (consume) begin
          if (xfer_last)      state_d = PS_IDLE;
          else if (burst_end) state_d = PS_GAP;
        end
      end
      PS_GAP:  state_d = PS_REQ;
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == PS_IDLE && start) begin
        err_q  <= !cfg_ok;
        done_q <= cfg_ok && xfer_zero;
      end else if (consume && xfer_last) begin
        done_q <= 1'b1;
      end
    end
  end

  assign dreq    = (state_q == PS_REQ);
  assign done    = done_q;
  assign cfg_err = err_q;

  // R3, R4: a rejected configuration never leads to a request
  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !dreq);
endmodule

// File: rtl/dma_burst_pacer.sv
module dma_burst_pacer #(
  parameter int CFG_W   = 16,
  parameter int BURST_W = 13,
  parameter int XLEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CFG_W-1:0]  cfg_burst,
  input  logic              cfg_wide,
  input  logic [XLEN_W-1:0] xfer_len,
  input  logic              strobe,
  output logic              dreq,
  output logic              done,
  output logic              cfg_err
);
  logic [BURST_W-1:0] burst_val;
  logic cfg_ok, xfer_zero, load, reload, consume, burst_end, xfer_last;

  dma_pacer_cfg_check #(.CFG_W(CFG_W), .BURST_W(BURST_W), .XLEN_W(XLEN_W)) chk_i (
    .cfg_burst(cfg_burst), .cfg_wide(cfg_wide), .xfer_len(xfer_len),
    .burst_val(burst_val), .cfg_ok(cfg_ok), .xfer_zero(xfer_zero)
  );

  dma_pacer_counters #(.BURST_W(BURST_W), .XLEN_W(XLEN_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(load), .reload(reload), .consume(consume),
    .wide_in(cfg_wide), .burst_in(burst_val), .xfer_in(xfer_len),
    .burst_end(burst_end), .xfer_last(xfer_last)
  );

  dma_pacer_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ok(cfg_ok), .xfer_zero(xfer_zero),
    .strobe(strobe), .burst_end(burst_end), .xfer_last(xfer_last),
    .load(load), .reload(reload), .consume(consume),
    .dreq(dreq), .done(done), .cfg_err(cfg_err)
  );

  // R6: a drop without completion is refilled on the next cycle
  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dreq) && !done) |=> dreq);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: no request while completion is signalled
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dreq);
endmodule

// File: tb/dma_burst_pacer_tb_top.sv
module dma_burst_pacer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] cfg_burst = '0;
  logic cfg_wide = 1'b0;
  logic [15:0] xfer_len = '0;
  logic strobe = 1'b0;
  logic dreq, done, cfg_err;

  always #2.5 clk = ~clk;

  dma_burst_pacer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_burst(cfg_burst),
    .cfg_wide(cfg_wide), .xfer_len(xfer_len), .strobe(strobe),
    .dreq(dreq), .done(done), .cfg_err(cfg_err)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // behavioural reference
  bit m_active, m_gap, m_dreq, m_done, m_err;
  int m_left, m_cnt, m_blen, m_step;
  int moved, falls, dones;
  bit prev_dreq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_gap = 0; m_dreq = 0; m_done = 0; m_err = 0;
      m_left = 0; m_cnt = 0; m_blen = 0; m_step = 2;
    end else begin
      if (dreq && strobe) moved += (m_step);
      m_done = 0;
      if (!m_active) begin
        if (start) begin
          int b, g;
          b = int'(cfg_burst) % 8192;
          g = cfg_wide ? 4 : 2;
          if (b == 0 || (b % g) != 0 || (int'(xfer_len) % (b == 0 ? 1 : b)) != 0) begin
            m_err = 1;
          end else begin
            m_err = 0;
            if (xfer_len == 0) m_done = 1;
            else begin
              m_active = 1; m_left = int'(xfer_len); m_blen = b; m_cnt = b;
              m_step = g; m_dreq = 1;
            end
          end
        end
      end else if (m_gap) begin
        m_gap = 0; m_dreq = 1; m_cnt = m_blen;
      end else if (strobe) begin
        m_left -= m_step; m_cnt -= m_step;
        if (m_left == 0) begin
          m_done = 1; m_active = 0; m_dreq = 0;
        end else if (m_cnt == 0) begin
          m_gap = 1; m_dreq = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_tag, {29'd0, dreq, done, cfg_err}, {29'd0, m_dreq, m_done, m_err});
      if (prev_dreq && !dreq) falls++;
      if (done) dones++;
      prev_dreq = dreq;
    end
  end

  task automatic run(input logic [15:0] b, input logic w, input logic [15:0] n,
                     input string tag, input int pat, input bit mid);
    int exp_falls, exp_dones, exp_moved, bl;
    bit ok;
    @(negedge clk); #1;
    cur_tag = tag; moved = 0; falls = 0; dones = 0;
    cfg_burst = b; cfg_wide = w; xfer_len = n; start = 1; strobe = 0;
    @(negedge clk); #1;
    start = 0;
    for (int i = 0; i < 400; i++) begin
      if (!m_active) break;
      strobe = (pat == 0) ? 1'b1 : ((i % pat) != 0);
      if (mid && i == 3) begin
        start = 1; cfg_burst = 16'h0003; cfg_wide = ~w; xfer_len = 16'd5;
      end else start = 0;
      @(negedge clk); #1;
    end
    start = 0; strobe = 0;
    repeat (2) @(negedge clk);
    #1;
    bl = int'(b) % 8192;
    ok = !(bl == 0 || (bl % (w ? 4 : 2)) != 0 || (int'(n) % (bl == 0 ? 1 : bl)) != 0);
    exp_moved = ok ? int'(n) : 0;
    exp_falls = (ok && n != 0) ? int'(n) / bl : 0;
    exp_dones = ok ? 1 : 0;
    chk({tag, " bytes"}, moved, exp_moved);
    chk({tag, " drops"}, falls, exp_falls);
    chk({tag, " done"}, dones, exp_dones);
    chk({tag, " err"}, int'(cfg_err), ok ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {29'd0, dreq, done, cfg_err}, 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 idle", {29'd0, dreq, done, cfg_err}, 0);
    run(16'hE008, 1'b0, 16'd16, "R2", 0, 0);
    run(16'd12, 1'b1, 16'd36, "R5", 3, 0);
    run(16'd8, 1'b0, 16'd24, "R6", 2, 0);
    run(16'd2, 1'b0, 16'd6, "R7", 0, 0);
    run(16'd4, 1'b1, 16'd12, "R7", 4, 0);
    run(16'd3, 1'b0, 16'd6, "R3", 0, 0);
    run(16'd6, 1'b1, 16'd12, "R3", 0, 0);
    run(16'd0, 1'b0, 16'd8, "R3", 0, 0);
    run(16'd8, 1'b0, 16'd12, "R4", 0, 0);
    run(16'd16, 1'b1, 16'd64, "R9", 0, 1);
    run(16'd6, 1'b0, 16'd18, "R10", 0, 0);
    run(16'd5, 1'b0, 16'd10, "R10", 0, 0);
    run(16'd8, 1'b1, 16'd0, "R10", 0, 0);
    run(16'd8, 1'b0, 16'd32, "R8", 2, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule